// File: doc/BRIEF.md
# Byte-Wide Access Bridge for 16-bit Timer Registers

This block lets an 8-bit register bus reach the 16-bit registers of a running timer: the live counter and two compare values. It is built so that every access sees or changes one consistent 16-bit value, even while the counter keeps counting between the two byte accesses. A single holding byte is shared by all three registers. Reading the low half captures the matching upper half into that holding byte. Writing the upper half only fills the holding byte. Writing the low half commits both halves in one cycle.

The counter itself lives outside the bridge. The bridge takes its live value, returns a one-cycle load request with the full 16-bit value, and masks the count enable in any cycle where a load is applied. Each compare value is kept in a buffer. An active copy follows that buffer right away outside PWM operation, and only at the counter's bottom cycle during PWM operation.

Top module: `reg16_access_bridge`

## Requirements
- R1: While reset is asserted, and at release, `bus_rdata`, both active compare values and the holding byte are zero, and `cnt_load` is low.
- R2: Address map: `bus_addr[0]` selects the byte (0 = bits 7:0, 1 = bits 15:8). `bus_addr[2:1]` selects the register (0 = counter, 1 = compare A, 2 = compare B, 3 = unused). Read data is registered. It shows up in the cycle after the read strobe and holds until the next read.
- R3: A low-byte read returns bits 7:0 of the selected register. In the same cycle it copies bits 15:8 of that register into the holding byte. For the counter, the bits come from `cnt_value` sampled in the strobe cycle.
- R4: A high-byte read returns the holding byte. Paired with an earlier low-byte read, it returns the upper half of the same counter value, even if the counter has carried since.
- R5: A high-byte write only loads the holding byte. The counter load request stays low and no compare buffer changes.
- R6: A low-byte write commits {holding byte, write data} in one cycle. For the counter, `cnt_load` is high for exactly the next cycle and `cnt_load_val` carries the value. For a compare register, the buffer takes the value at that edge.
- R7: A high-byte write that is not followed by a low-byte write leaves every target register unchanged.
- R8: A high-byte read with no low-byte read before it returns whatever the holding byte last received, from a high-byte write or from an earlier low-byte read of any register.
- R9: The holding byte is shared. A high-byte write aimed at one register followed by a low-byte write to another register commits that byte into the second register.
- R10: In any cycle where `cnt_load` is high, `timer_tick_out` is low, whatever `timer_tick_in` is. Otherwise it equals `timer_tick_in`.
- R11: With `pwm_mode` low, a compare register's active value takes the committed value at the same edge as its buffer.
- R12: With `pwm_mode` high, the active value copies the buffer only at edges where `at_bottom` is high. At all other edges it holds.
- R13: Accesses to register 3 change nothing and read back zero. When the write and read strobes are both high, the write takes effect and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Byte select (bit 0) and register select (bits 2:1) |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_rdata | output | 8 | Registered read data |
| cnt_value | input | 16 | Live counter value from the timer |
| timer_tick_in | input | 1 | Count enable requested by the prescaler |
| timer_tick_out | output | 1 | Count enable passed to the counter, masked during a load |
| cnt_load | output | 1 | Counter load request, one cycle |
| cnt_load_val | output | 16 | Value to load into the counter |
| pwm_mode | input | 1 | High when the timer runs a PWM waveform |
| at_bottom | input | 1 | High in the counter's bottom cycle |
| cmp_a_active | output | 16 | Active compare A value |
| cmp_b_active | output | 16 | Active compare B value |

## Verification
The assertions check these rules on every cycle:
- read data holds between reads;
- a high-byte read returns the previous holding byte;
- a high-byte write never raises a counter load;
- a counter commit carries exactly {holding byte, data};
- compare buffers move only on a commit;
- active values freeze in PWM operation away from the bottom cycle.

Some behaviour only shows up across a sequence, and only the bench scenarios can show it:
- the coherence of a low/high read pair across a counter carry;
- the stale holding byte returned by a lone high-byte read;
- the cross-register corruption from interleaved accesses;
- the masked tick during a load.

A behavioural model of the bridge and of the timer counter checks these every cycle.

// File: rtl/reg16_bridge_pkg.sv
package reg16_bridge_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CMPA = 2'd1,
    SEL_CMPB = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Register select from the two select bits of the bus address.
  function automatic reg_sel_e decode_sel(input logic [1:0] sel_bits);
    return reg_sel_e'(sel_bits);
  endfunction

  // Compare slot index (0-based) to its register select code.
  function automatic reg_sel_e slot_sel(input int slot);
    return reg_sel_e'(slot + 1);
  endfunction

endpackage

// File: rtl/bridge_decode.sv
module bridge_decode
  import reg16_bridge_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output reg_sel_e          sel,
  output logic              ev_wr_hi,
  output logic              ev_wr_lo,
  output logic              ev_rd_hi,
  output logic              ev_rd_lo,
  output logic              ev_rd_void
);
  logic valid;
  logic rd_eff;

  always_comb begin
    sel        = decode_sel(addr[2:1]);
    valid      = (sel != SEL_NONE);
    rd_eff     = rd && !wr;          // write wins when both strobes are high
    ev_wr_hi   = wr && valid && addr[0];
    ev_wr_lo   = wr && valid && !addr[0];
    ev_rd_hi   = rd_eff && valid && addr[0];
    ev_rd_lo   = rd_eff && valid && !addr[0];
    ev_rd_void = rd_eff && !valid;
  end
endmodule

// File: rtl/bridge_hold.sv
module bridge_hold #(
  parameter int BYTE_W = 8,
  localparam int REG_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_wr_hi,
  input  logic              ev_rd_hi,
  input  logic              ev_rd_lo,
  input  logic              ev_rd_void,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [REG_W-1:0]  live_val,
  output logic [BYTE_W-1:0] hold_q,
  output logic [BYTE_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      rdata_q <= '0;
    end else if (ev_wr_hi) begin
      hold_q <= wdata;
    end else if (ev_rd_lo) begin
      rdata_q <= live_val[BYTE_W-1:0];
      hold_q  <= live_val[REG_W-1:BYTE_W];
    end else if (ev_rd_hi) begin
      rdata_q <= hold_q;
    end else if (ev_rd_void) begin
      rdata_q <= '0;
    end
  end

  a_r4_high_read_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_hi |=> rdata_q == $past(hold_q));

  a_r2_rdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rd_hi || ev_rd_lo || ev_rd_void) |=> $stable(rdata_q));

  a_r5_hi_write_loads_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_hi |=> hold_q == $past(wdata));
endmodule

// File: rtl/bridge_cmp_slot.sv
module bridge_cmp_slot #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [REG_W-1:0] commit_val,
  input  logic             pwm_mode,
  input  logic             at_bottom,
  output logic [REG_W-1:0] buf_q,
  output logic [REG_W-1:0] active_q
);
  logic [REG_W-1:0] buf_next;

  always_comb buf_next = commit ? commit_val : buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q    <= '0;
      active_q <= '0;
    end else begin
      buf_q <= buf_next;
      if (!pwm_mode)
        active_q <= buf_next;
      else if (at_bottom)
        active_q <= buf_q;
    end
  end

  a_r7_buf_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(buf_q));

  a_r11_direct_update: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode && commit) |=> active_q == $past(commit_val));

  a_r12_pwm_waits_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !at_bottom) |=> $stable(active_q));
endmodule

// File: rtl/reg16_access_bridge.sv
module reg16_access_bridge
  import reg16_bridge_pkg::*;
#(
  parameter int BYTE_W = reg16_bridge_pkg::BYTE_W,
  parameter int ADDR_W = 3,
  localparam int REG_W = 2 * BYTE_W,
  localparam int NUM_CMP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [REG_W-1:0]  cnt_value,
  input  logic              timer_tick_in,
  output logic              timer_tick_out,
  output logic              cnt_load,
  output logic [REG_W-1:0]  cnt_load_val,
  input  logic              pwm_mode,
  input  logic              at_bottom,
  output logic [REG_W-1:0]  cmp_a_active,
  output logic [REG_W-1:0]  cmp_b_active
);
  reg_sel_e          sel;
  logic              ev_wr_hi, ev_wr_lo, ev_rd_hi, ev_rd_lo, ev_rd_void;
  logic [BYTE_W-1:0] hold_q;
  logic [REG_W-1:0]  commit_val;
  logic [REG_W-1:0]  live_val;
  logic              cnt_commit;
  logic [REG_W-1:0]  cmp_buf    [NUM_CMP];
  logic [REG_W-1:0]  cmp_active [NUM_CMP];

  bridge_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .sel(sel),
    .ev_wr_hi(ev_wr_hi), .ev_wr_lo(ev_wr_lo),
    .ev_rd_hi(ev_rd_hi), .ev_rd_lo(ev_rd_lo), .ev_rd_void(ev_rd_void)
  );

  bridge_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .ev_wr_hi(ev_wr_hi), .ev_rd_hi(ev_rd_hi), .ev_rd_lo(ev_rd_lo),
    .ev_rd_void(ev_rd_void), .wdata(bus_wdata), .live_val(live_val),
    .hold_q(hold_q), .rdata_q(bus_rdata)
  );

  always_comb begin
    commit_val = {hold_q, bus_wdata};
    cnt_commit = ev_wr_lo && (sel == SEL_CNT);
  end

  // Live value of the selected register, seen by a low-byte read.
  always_comb begin
    live_val = '0;
    if (sel == SEL_CNT) live_val = cnt_value;
    for (int i = 0; i < NUM_CMP; i++)
      if (sel == slot_sel(i)) live_val = cmp_buf[i];
  end

  generate
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      logic slot_commit;
      always_comb slot_commit = ev_wr_lo && (sel == slot_sel(g));
      bridge_cmp_slot #(.REG_W(REG_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .commit(slot_commit), .commit_val(commit_val),
        .pwm_mode(pwm_mode), .at_bottom(at_bottom),
        .buf_q(cmp_buf[g]), .active_q(cmp_active[g])
      );
    end
  endgenerate

  always_comb begin
    cmp_a_active = cmp_active[0];
    cmp_b_active = cmp_active[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_load     <= 1'b0;
      cnt_load_val <= '0;
    end else begin
      cnt_load <= cnt_commit;
      if (cnt_commit) cnt_load_val <= commit_val;
    end
  end

  // A load overrides the count enable in the cycle it is applied.
  always_comb timer_tick_out = timer_tick_in && !cnt_load;

  a_r6_counter_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr[0] && bus_addr[2:1] == 2'd0)
      |=> (cnt_load && cnt_load_val == $past({hold_q, bus_wdata})));

  a_r5_hi_write_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[0]) |=> !cnt_load);

  a_r13_unused_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[2:1] == 2'd3) |=> !cnt_load);

  a_r6_load_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_load && !$past(cnt_commit)) |-> 1'b0);
endmodule

// File: tb/reg16_access_bridge_bench.sv
module reg16_access_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [15:0] tcnt = '0;
  logic        tick_in = 1'b0, tick_out;
  logic        cnt_load;
  logic [15:0] cnt_load_val, act_a, act_b;
  logic        pwm = 1'b0, bottom = 1'b0;

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  // Reference model state
  logic [7:0]  m_rdata, m_hold;
  logic        m_load;
  logic [15:0] m_loadv;
  logic [15:0] m_buf [2];
  logic [15:0] m_act [2];

  always #2.5 clk = ~clk;

  reg16_access_bridge u_reg16_access_bridge (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cnt_value(tcnt), .timer_tick_in(tick_in), .timer_tick_out(tick_out),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .pwm_mode(pwm), .at_bottom(bottom),
    .cmp_a_active(act_a), .cmp_b_active(act_b)
  );

  // Behavioural model of the bridge plus the external timer counter.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rdata = 0; m_hold = 0; m_load = 0; m_loadv = 0;
      m_buf[0] = 0; m_buf[1] = 0; m_act[0] = 0; m_act[1] = 0;
      tcnt <= 0;
    end else begin
      automatic int          reg_no   = int'(bus_addr[2:1]);
      automatic logic [15:0] live     = 0;
      automatic logic [7:0]  old_hold = m_hold;
      automatic logic [15:0] old_buf0 = m_buf[0];
      automatic logic [15:0] old_buf1 = m_buf[1];
      automatic logic        prev_ld  = m_load;
      automatic logic [15:0] prev_ldv = m_loadv;
      if (reg_no == 0) live = tcnt;
      else if (reg_no < 3) live = m_buf[reg_no-1];
      m_load = 0;
      if (bus_wr) begin
        if (reg_no != 3) begin
          if (bus_addr[0]) m_hold = bus_wdata;
          else if (reg_no == 0) begin m_load = 1; m_loadv = {old_hold, bus_wdata}; end
          else m_buf[reg_no-1] = {old_hold, bus_wdata};
        end
      end else if (bus_rd) begin
        if (reg_no == 3) m_rdata = 0;
        else if (bus_addr[0]) m_rdata = old_hold;
        else begin m_rdata = live[7:0]; m_hold = live[15:8]; end
      end
      if (!pwm) begin m_act[0] = m_buf[0]; m_act[1] = m_buf[1]; end
      else if (bottom) begin m_act[0] = old_buf0; m_act[1] = old_buf1; end
      if (prev_ld) tcnt <= prev_ldv;
      else if (tick_in) tcnt <= tcnt + 16'd1;
    end
  end

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk("rdata", {8'h0, bus_rdata}, {8'h0, m_rdata});
      chk("cnt_load", {15'h0, cnt_load}, {15'h0, m_load});
      chk("cnt_load_val", cnt_load_val, m_loadv);
      chk("cmp_a_active", act_a, m_act[0]);
      chk("cmp_b_active", act_b, m_act[1]);
      chk("tick_out (R10)", {15'h0, tick_out}, {15'h0, tick_in & ~m_load});
    end
  end

  task automatic op(input logic [2:0] a, input logic [7:0] d, input logic w, input logic r);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    idle(3);
    chk("reset rdata R1", {8'h0, bus_rdata}, 16'h0);
    chk("reset active R1", act_a | act_b, 16'h0);
    @(negedge clk) rst_n = 1;
    idle(2);

    cur_req = "R6";   // counter commit: 0x12FE, then run across a carry
    op(3'b001, 8'h12, 1, 0);
    op(3'b000, 8'hFE, 1, 0);
    tick_in = 1;
    idle(1);

    cur_req = "R3";   // low read near the carry, high read after it
    op(3'b000, 8'h00, 0, 1);
    idle(4);
    cur_req = "R4";
    op(3'b001, 8'h00, 0, 1);
    idle(2);

    cur_req = "R5";   // lone high write to compare A
    op(3'b011, 8'h55, 1, 0);
    cur_req = "R7";
    idle(5);
    cur_req = "R8";   // stale holding byte back
    op(3'b011, 8'h00, 0, 1);
    op(3'b101, 8'h00, 0, 1);

    cur_req = "R9";   // shared byte crosses registers
    op(3'b011, 8'h34, 1, 0);
    op(3'b100, 8'h78, 1, 0);
    cur_req = "R11";
    op(3'b010, 8'h9A, 1, 0);
    op(3'b010, 8'h00, 0, 1);
    op(3'b011, 8'h00, 0, 1);

    cur_req = "R10";  // load while ticking
    op(3'b001, 8'hAB, 1, 0);
    op(3'b000, 8'hCD, 1, 0);
    idle(2);

    cur_req = "R12";
    pwm = 1;
    op(3'b001, 8'h01, 1, 0);
    op(3'b010, 8'h10, 1, 0);
    idle(3);
    @(negedge clk) bottom = 1;
    @(negedge clk) bottom = 0;
    op(3'b100, 8'h20, 1, 0);
    idle(2);
    @(negedge clk) bottom = 1;
    @(negedge clk) bottom = 0;
    pwm = 0;
    idle(1);

    cur_req = "R13";
    op(3'b111, 8'hEE, 1, 0);
    op(3'b110, 8'hEE, 1, 0);
    op(3'b110, 8'h00, 0, 1);
    op(3'b000, 8'h00, 0, 1);
    op(3'b001, 8'h66, 1, 1);
    op(3'b000, 8'h77, 1, 1);

    cur_req = "R2";   // random traffic, model compares every cycle
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      bus_addr  = 3'($urandom);
      bus_wdata = 8'($urandom);
      bus_wr    = ($urandom % 3) == 0;
      bus_rd    = ($urandom % 2) == 0;
      tick_in   = ($urandom % 4) != 0;
      bottom    = ($urandom % 5) == 0;
      if (i % 97 == 0) pwm = ~pwm;
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    idle(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule